// File: doc/BRIEF.md
# Word-to-Byte Serial Transmitter

This block sends a 16-bit data word on an asynchronous serial line. A source pulses a strobe alongside the word. The block copies the word into a holding register and sends it as two 8-bit character frames, upper half first. Each frame carries one start bit, eight data bits, an even-parity bit and one stop bit. The data bits are sent least-significant bit first, and the line rests high between frames.

The block has two parts. A sequencer walks through the held word one byte at a time. A serializer owns its own shift register and drives the line. The sequencer offers a byte only when the serializer reports that it is idle, so the serializer never loses a byte to a newer one. The bit period is the system clock rate divided by the baud rate. The defaults are 50 MHz and 19200 baud, which gives 2604 clocks per bit.

A strobe can arrive while a word is still being sent. In that case the block keeps the new word pending and sends it only after the current word has gone out. If several strobes arrive in that time, the last one replaces the earlier ones.

Top module: `word_uart_tx`

## Requirements
- R1: After reset the serial line `txd_o` is high and `busy_o` is low. The line is high again once all sending has ended.
- R2: Each frame starts with a low start bit. It then carries 8 data bits, least-significant bit first, followed by the parity bit and a high stop bit. Each bit lasts exactly CLK_HZ/BAUD clocks.
- R3: The parity bit is the XOR of the eight data bits, so the number of ones across data and parity is even.
- R4: A word is sent as two frames. Bits 15..8 go in the first frame and bits 7..0 in the second.
- R5: The word is captured on the clock edge where `word_valid_i` is high and the block is idle. Later changes on `word_i` have no effect on the frames of that word.
- R6: A strobe that arrives while busy is kept pending and is sent after both frames of the current word. If several strobes arrive while busy, only the last word is kept.
- R7: `busy_o` goes high on the cycle after an accepted strobe. It stays high until the stop bit of the last frame has ended and no word is pending.
- R8: A byte is handed to the serializer only when the serializer is idle. Two consecutive start edges are therefore at least 11 bit periods apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid_i | input | 1 | One-cycle strobe: `word_i` holds a new word |
| word_i | input | WORD_W | Data word to send |
| txd_o | output | 1 | Serial transmit line, idles high |
| busy_o | output | 1 | High while a word is being sent or is pending |

## Verification
The bench builds the block with CLK_HZ = 800 and BAUD = 100, which gives eight clocks per bit. With such a short bit period, many complete two-frame words fit in a short run. Pending and replaced strobes can then be placed in the middle of a frame. The monitor samples every bit at mid-period and checks the spacing between start edges, the parity of varied bytes, and the exact point where busy drops after the last stop bit.

// File: rtl/wtx_pkg.sv
package wtx_pkg;

    typedef enum logic [2:0] {
        LN_IDLE,
        LN_START,
        LN_DATA,
        LN_PAR,
        LN_STOP
    } line_state_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LOAD,
        SQ_WAIT
    } seq_state_e;

    function automatic int bit_period(input int clk_hz, input int baud);
        return clk_hz / baud;
    endfunction

endpackage

// File: rtl/wtx_baud.sv
module wtx_baud #(
    parameter int DIV = 2604
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick_o = (cnt_q == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: divider never passes its terminal count
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DIV - 1));

endmodule

// File: rtl/wtx_serializer.sv
module wtx_serializer
    import wtx_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DIV    = 2604
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              ready_o,
    output logic              txd_o
);
    localparam int BW = $clog2(BYTE_W);

    line_state_e       state_q;
    logic [BYTE_W-1:0] shift_q;
    logic [BW-1:0]     idx_q;
    logic              par_q;
    logic              txd_q;
    logic              tick;

    wtx_baud #(.DIV(DIV)) u_baud (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (state_q == LN_IDLE),
        .tick_o (tick)
    );

    assign ready_o = (state_q == LN_IDLE);
    assign txd_o   = txd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LN_IDLE;
            shift_q <= '0;
            idx_q   <= '0;
            par_q   <= 1'b0;
            txd_q   <= 1'b1;
        end else begin
            unique case (state_q)
                LN_IDLE: begin
                    txd_q <= 1'b1;
                    if (load_i) begin
                        shift_q <= byte_i;
                        par_q   <= ^byte_i;
                        txd_q   <= 1'b0;
                        state_q <= LN_START;
                    end
                end
                LN_START: if (tick) begin
                    txd_q   <= shift_q[0];
                    shift_q <= shift_q >> 1;
                    idx_q   <= '0;
                    state_q <= LN_DATA;
                end
                LN_DATA: if (tick) begin
                    if (idx_q == BW'(BYTE_W - 1)) begin
                        txd_q   <= par_q;
                        state_q <= LN_PAR;
                    end else begin
                        txd_q   <= shift_q[0];
                        shift_q <= shift_q >> 1;
                        idx_q   <= idx_q + 1'b1;
                    end
                end
                LN_PAR: if (tick) begin
                    txd_q   <= 1'b1;
                    state_q <= LN_STOP;
                end
                LN_STOP: if (tick) begin
                    state_q <= LN_IDLE;
                end
                default: state_q <= LN_IDLE;
            endcase
        end
    end

    // R2: the line is high for the whole stop bit
    assert_stop_high_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == LN_STOP) |-> txd_o);

    // R1: an idle serializer leaves the line high from the next cycle on
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
        (ready_o && !load_i) |=> txd_o);

endmodule

// File: rtl/wtx_sequencer.sv
module wtx_sequencer
    import wtx_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_valid_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              tx_ready_i,
    output logic              load_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              busy_o
);
    localparam int NBYTES = WORD_W / BYTE_W;
    localparam int IW     = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    seq_state_e        state_q;
    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] pend_word_q;
    logic              pend_q;
    logic [IW-1:0]     idx_q;
    logic [WORD_W-1:0] aligned;

    assign aligned = hold_q << (int'(idx_q) * BYTE_W);
    assign byte_o  = aligned[WORD_W-1 -: BYTE_W];
    assign load_o  = (state_q == SQ_LOAD) && tx_ready_i;
    assign busy_o  = (state_q != SQ_IDLE) || pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= SQ_IDLE;
            hold_q      <= '0;
            pend_word_q <= '0;
            pend_q      <= 1'b0;
            idx_q       <= '0;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    idx_q <= '0;
                    if (word_valid_i) begin
                        hold_q  <= word_i;
                        pend_q  <= 1'b0;
                        state_q <= SQ_LOAD;
                    end else if (pend_q) begin
                        hold_q  <= pend_word_q;
                        pend_q  <= 1'b0;
                        state_q <= SQ_LOAD;
                    end
                end
                SQ_LOAD: if (load_o) state_q <= SQ_WAIT;
                SQ_WAIT: if (tx_ready_i) begin
                    if (idx_q == IW'(NBYTES - 1)) begin
                        state_q <= SQ_IDLE;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= SQ_LOAD;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
            if (state_q != SQ_IDLE && word_valid_i) begin
                pend_q      <= 1'b1;
                pend_word_q <= word_i;
            end
        end
    end

    // R5: the held word never changes while a transfer runs
    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q != SQ_IDLE) |=> $stable(hold_q));

    // R7: an accepted strobe raises busy on the next cycle
    assert_busy_rise_R7: assert property (@(posedge clk) disable iff (rst)
        (word_valid_i && !busy_o) |=> busy_o);

endmodule

// File: rtl/word_uart_tx.sv
module word_uart_tx
    import wtx_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int BAUD   = 19200,
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_valid_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              txd_o,
    output logic              busy_o
);
    localparam int DIV = bit_period(CLK_HZ, BAUD);

    logic              tx_ready;
    logic              load;
    logic [BYTE_W-1:0] tx_byte;

    wtx_sequencer #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .word_valid_i (word_valid_i),
        .word_i       (word_i),
        .tx_ready_i   (tx_ready),
        .load_o       (load),
        .byte_o       (tx_byte),
        .busy_o       (busy_o)
    );

    wtx_serializer #(.BYTE_W(BYTE_W), .DIV(DIV)) u_ser (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .byte_i  (tx_byte),
        .ready_o (tx_ready),
        .txd_o   (txd_o)
    );

    // R8: a byte is handed over only to an idle serializer
    assert_load_idle_R8: assert property (@(posedge clk) disable iff (rst)
        load |-> tx_ready);

    // R2: a handed-over byte starts with a low start bit
    assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> !txd_o);

    // R7: busy covers every moment the line is not idle
    assert_busy_cover_R7: assert property (@(posedge clk) disable iff (rst)
        !txd_o |-> busy_o);

endmodule

// File: tb/tb_word_uart_tx.sv
module tb_word_uart_tx;
    localparam int CLK_HZ = 800;
    localparam int BAUD   = 100;
    localparam int DIV    = CLK_HZ / BAUD;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        word_valid_i = 1'b0;
    logic [15:0] word_i = '0;
    logic        txd_o;
    logic        busy_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;
    logic [7:0] exp_q[$];

    word_uart_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .WORD_W(16), .BYTE_W(8)) dut (
        .clk          (clk),
        .rst          (rst),
        .word_valid_i (word_valid_i),
        .word_i       (word_i),
        .txd_o        (txd_o),
        .busy_o       (busy_o)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // driver: pulses a strobe, pushes expected bytes (R4: high byte first)
    task automatic send(input logic [15:0] w, input bit push);
        @(negedge clk);
        word_i       = w;
        word_valid_i = 1'b1;
        if (push) begin
            exp_q.push_back(w[15:8]);
            exp_q.push_back(w[7:0]);
        end
        @(negedge clk);
        word_valid_i = 1'b0;
    endtask

    // monitor: decodes frames at mid-bit and checks them against the scoreboard
    initial begin
        logic prev;
        int   last_fall;
        prev      = 1'b1;
        last_fall = -1;
        forever begin
            @(negedge clk);
            if (!rst && prev && !txd_o) begin
                logic [7:0] data;
                logic       par;
                logic       stop;
                logic [7:0] exp;
                if (last_fall >= 0)
                    check(cyc - last_fall >= 11 * DIV, "R8 start spacing", cyc - last_fall, 11 * DIV);
                last_fall = cyc;
                repeat (DIV / 2) @(negedge clk);
                check(txd_o == 1'b0, "R2 start bit", int'(txd_o), 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (DIV) @(negedge clk);
                    data[i] = txd_o;
                end
                repeat (DIV) @(negedge clk);
                par = txd_o;
                repeat (DIV) @(negedge clk);
                stop = txd_o;
                check(par == ^data, "R3 even parity", int'(par), int'(^data));
                check(stop == 1'b1, "R2 stop bit", int'(stop), 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected frame", int'(data), 0);
                end else begin
                    exp = exp_q.pop_front();
                    check(data == exp, "R4/R5/R6 frame byte", int'(data), int'(exp));
                end
            end
            prev = txd_o;
        end
    end

    task automatic wait_idle(input string req);
        while (busy_o !== 1'b0) @(negedge clk);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
        @(negedge clk);
        check(txd_o == 1'b1, "R1 line idle after transfer", int'(txd_o), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(txd_o == 1'b1, "R1 reset line", int'(txd_o), 1);
        check(busy_o == 1'b0, "R1 reset busy", int'(busy_o), 0);

        // R4 order, R7 busy rise, R5 word changes after capture
        send(16'h4563, 1'b1);
        check(busy_o == 1'b1, "R7 busy after strobe", int'(busy_o), 1);
        word_i = 16'hFFFF;
        repeat (5 * DIV) @(negedge clk);
        word_i = 16'h0000;
        wait_idle("R7 busy held until last stop");

        // R6: pending strobe, latest replaces earlier
        send(16'h00FF, 1'b1);
        repeat (3 * DIV) @(negedge clk);
        send(16'h1234, 1'b0);
        repeat (14 * DIV) @(negedge clk);
        send(16'h0F0F, 1'b1);
        repeat (12 * DIV) @(negedge clk);
        check(busy_o == 1'b1, "R6 busy while pending", int'(busy_o), 1);
        wait_idle("R6 pending word sent");

        // R3 parity on varied bytes, R2 format
        send(16'h0180, 1'b1);
        wait_idle("R3 parity words");
        send(16'h7E01, 1'b1);
        wait_idle("R3 parity words");
        send(16'hA5C3, 1'b1);
        wait_idle("R2 frame format");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule